// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes the 16-bit check value that guards the serial-bus topology and speed map blocks. Software or a map builder pulses `start_i` together with the number of 32-bit quadlets to be covered. For a topology map that number is the self-ID count plus 2. The engine then takes one quadlet at a time over a valid/ready handshake.

Each accepted quadlet is folded into the running CRC four bits per clock, most significant nibble first. A quadlet therefore occupies the engine for eight cycles, and the first nibble is digested on the accepting edge. When the last nibble of the last quadlet has been folded in, `done_o` pulses for one cycle. The result stays on `crc_o` until the next start.

Top module: `crc_quad_nibble`

## Requirements
- R1: While `rst_ni` is low, `crc_o` is 0 and both `in_ready_o` and `done_o` are 0.
- R2: A `start_i` pulse clears the CRC to 0 and loads `count_i`; the cycle after it, `crc_o` reads 0 and `in_ready_o` is 1 if the count is non-zero.
- R3: Each nibble updates the CRC as follows: s = (crc[15:12] XOR nibble) AND 0xF, then crc' = ((crc << 4) XOR (s << 12) XOR (s << 5) XOR s) truncated to 16 bits. Nibbles are taken from bits 31:28 down to bits 3:0.
- R4: The 16-bit state carries from one quadlet into the next, so the result for N quadlets equals the nibble-loop over all 8N nibbles starting from 0.
- R5: After a quadlet is accepted, `in_ready_o` stays low for the following 7 cycles. It rises again on the 8th cycle only if quadlets remain.
- R6: `done_o` is high for exactly one cycle. It is first seen 7 cycles after the edge that accepted the final quadlet.
- R7: After `done_o`, `crc_o` holds its value and `in_ready_o` stays low until the next start, whatever `in_valid_i` and `in_data_i` do.
- R8: A start with a count of 0 raises `done_o` in the very next cycle, with `crc_o` = 0.
- R9: A start issued while a quadlet is being digested aborts it. The result then covers only the quadlets accepted after that start.
- R10: While `in_ready_o` is low, `in_valid_i` and `in_data_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear CRC and load quadlet count |
| count_i | input | CNT_W | Number of quadlets in the block |
| in_valid_i | input | 1 | Quadlet offered |
| in_data_i | input | QUAD_W | Quadlet data |
| in_ready_o | output | 1 | Engine can take a quadlet |
| done_o | output | 1 | One-cycle pulse when the result is final |
| crc_o | output | 16 | Running / final CRC |

## Verification
A wrong nibble index or shift register shows up as a wrong `crc_o` no later than the `done_o` of the same block. The bench sweeps every nibble value at every nibble position to catch ordering and XOR-tap errors. A miscounted nibble counter or quadlet count moves `done_o` or the reopening of `in_ready_o` by a cycle, which is checked at an exact cycle offset from each accept. A leak of input data or state between runs appears in the next block's result or as a change of the held `crc_o`.

// File: rtl/crc_quad_pkg.sv
package crc_quad_pkg;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;
  localparam int TAP_HI = 12;
  localparam int TAP_MID = 5;
  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/crc_nib_step.sv
module crc_nib_step
  import crc_quad_pkg::*;
(
  input  crc_t crc_i,
  input  nib_t nib_i,
  output crc_t crc_o
);
  nib_t sum;
  crc_t sum_w;

  always_comb begin
    sum   = crc_i[CRC_W-1 -: NIB_W] ^ nib_i;
    sum_w = crc_t'(sum);
    crc_o = (crc_i << NIB_W) ^ (sum_w << TAP_HI) ^ (sum_w << TAP_MID) ^ sum_w;
  end
endmodule

// File: rtl/crc_nib_seq.sv
module crc_nib_seq #(
  parameter int CNT_W = 16,
  parameter int NIBS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic             digest_o,
  output logic             done_o
);
  localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [CNT_W-1:0] left_q;
  logic [IDX_W-1:0] nib_q;
  logic             shift_q;
  logic             done_q;

  assign in_ready_o = (left_q != '0) && !shift_q;
  assign accept_o   = in_valid_i && in_ready_o && !start_i;
  assign digest_o   = shift_q && !start_i;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      nib_q   <= '0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        left_q  <= count_i;
        nib_q   <= '0;
        shift_q <= 1'b0;
        done_q  <= (count_i == '0);
      end else if (accept_o) begin
        // first nibble is folded on the accepting edge
        shift_q <= 1'b1;
        nib_q   <= IDX_W'(1);
      end else if (shift_q) begin
        if (nib_q == LAST_IDX) begin
          shift_q <= 1'b0;
          nib_q   <= '0;
          left_q  <= left_q - 1'b1;
          done_q  <= (left_q == CNT_W'(1));
        end else begin
          nib_q <= nib_q + 1'b1;
        end
      end
    end
  end

  assert_ready_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o) |=> !in_ready_o);
  assert_busy_has_work_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q |-> (left_q != '0));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_zero_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && count_i == '0) |=> done_o);
endmodule

// File: rtl/crc_quad_nibble.sv
module crc_quad_nibble
  import crc_quad_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int QUAD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              in_valid_i,
  input  logic [QUAD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int NIBS = QUAD_W / NIB_W;

  logic              accept;
  logic              digest;
  logic [QUAD_W-1:0] shreg_q;
  crc_t              crc_q;
  crc_t              crc_nx;
  nib_t              nib_in;

  crc_nib_seq #(.CNT_W(CNT_W), .NIBS(NIBS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .digest_o   (digest),
    .done_o     (done_o)
  );

  assign nib_in = accept ? in_data_i[QUAD_W-1 -: NIB_W] : shreg_q[QUAD_W-1 -: NIB_W];

  crc_nib_step u_step (
    .crc_i (crc_q),
    .nib_i (nib_in),
    .crc_o (crc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      crc_q   <= '0;
      shreg_q <= '0;
    end else if (accept) begin
      crc_q   <= crc_nx;
      shreg_q <= in_data_i << NIB_W;
    end else if (digest) begin
      crc_q   <= crc_nx;
      shreg_q <= shreg_q << NIB_W;
    end
  end

  assign crc_o = crc_q;

  assert_start_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (crc_o == '0));
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !in_ready_o && !digest && !accept) |=> $stable(crc_o));
  assert_zero_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && count_i == '0) |=> (done_o && crc_o == '0));
  assert_no_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest |-> !accept);
endmodule

// File: tb/crc_quad_nibble_tb.sv
module crc_quad_nibble_tb;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] count_i = '0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o;
  logic        done_o;
  logic [15:0] crc_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] qbuf [0:15];

  always #5 clk = ~clk;

  crc_quad_nibble #(.CNT_W(CNT_W), .QUAD_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .done_o(done_o), .crc_o(crc_o)
  );

  function automatic logic [15:0] ref_crc(int n);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      for (int sh = 28; sh >= 0; sh -= 4) begin
        int s;
        s = ((c >> 12) ^ int'(qbuf[i] >> sh)) & 15;
        c = ((c << 4) ^ (s << 12) ^ (s << 5) ^ s) & 16'hffff;
      end
    end
    return c[15:0];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic start_run(int n);
    @(negedge clk);
    start_i = 1'b1;
    count_i = 16'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(logic [31:0] d);
    in_valid_i = 1'b1;
    in_data_i  = d;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    in_data_i  = 32'hdead_beef;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_case(int n, string req);
    int cyc;
    start_run(n);
    for (int i = 0; i < n; i++) send(qbuf[i]);
    wait_done(cyc);
    chk(done_o, req, 32'(done_o), 1);
    chk(crc_o == ref_crc(n), req, 32'(crc_o), 32'(ref_crc(n)));
    @(negedge clk);
    chk(!done_o, "R6", 32'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(crc_o == 0 && !in_ready_o && !done_o, "R1", {crc_o, 14'd0, in_ready_o, done_o}, 0);
    rst_ni = 1'b1;

    // R2 start clears and opens ready
    start_run(2);
    chk(crc_o == 0, "R2", 32'(crc_o), 0);
    chk(in_ready_o, "R2", 32'(in_ready_o), 1);

    // R3 every nibble value at every position, single quadlet
    for (int pos = 0; pos < 8; pos++) begin
      for (int v = 0; v < 16; v++) begin
        qbuf[0] = (32'(v) << (pos * 4)) | 32'h0000_0000;
        run_case(1, "R3");
      end
    end

    // R4 multi-quadlet carry
    for (int n = 2; n <= 12; n++) begin
      for (int i = 0; i < n; i++) qbuf[i] = 32'(i + 1) * 32'h9e37_79b9 ^ 32'(n) * 32'h0101_0101;
      run_case(n, "R4");
    end

    // R5 / R6 timing
    qbuf[0] = 32'h1234_5678; qbuf[1] = 32'hcafe_f00d; qbuf[2] = 32'h0bad_c0de;
    start_run(3);
    send(qbuf[0]);
    for (int k = 0; k < 7; k++) begin
      chk(!in_ready_o, "R5", 32'(in_ready_o), 0);
      @(negedge clk);
    end
    chk(in_ready_o, "R5", 32'(in_ready_o), 1);
    send(qbuf[1]);
    send(qbuf[2]);
    wait_done(cyc);
    chk(cyc == 7, "R6", 32'(cyc), 7);
    chk(crc_o == ref_crc(3), "R6", 32'(crc_o), 32'(ref_crc(3)));
    @(negedge clk);
    chk(!done_o, "R6", 32'(done_o), 0);

    // R7 hold after done, input ignored
    held = crc_o;
    in_valid_i = 1'b1;
    in_data_i = 32'hffff_ffff;
    repeat (4) @(negedge clk);
    chk(crc_o == held, "R7", 32'(crc_o), 32'(held));
    chk(!in_ready_o, "R7", 32'(in_ready_o), 0);
    in_valid_i = 1'b0;

    // R8 zero count
    start_run(0);
    chk(done_o, "R8", 32'(done_o), 1);
    chk(crc_o == 0, "R8", 32'(crc_o), 0);
    @(negedge clk);
    chk(!done_o && !in_ready_o, "R8", {30'd0, done_o, in_ready_o}, 0);

    // R10 valid while busy ignored
    qbuf[0] = 32'ha5a5_0f0f; qbuf[1] = 32'h3c3c_7777;
    start_run(2);
    send(qbuf[0]);
    in_valid_i = 1'b1;
    in_data_i = 32'h5555_aaaa;
    repeat (3) @(negedge clk);
    in_valid_i = 1'b0;
    send(qbuf[1]);
    wait_done(cyc);
    chk(crc_o == ref_crc(2), "R10", 32'(crc_o), 32'(ref_crc(2)));

    // R9 restart mid-digest
    start_run(2);
    send(32'h7777_1111);
    repeat (3) @(negedge clk);
    qbuf[0] = 32'h0f1e_2d3c;
    start_run(1);
    chk(crc_o == 0, "R9", 32'(crc_o), 0);
    send(qbuf[0]);
    wait_done(cyc);
    chk(crc_o == ref_crc(1), "R9", 32'(crc_o), 32'(ref_crc(1)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule